// File: doc/BRIEF.md
# Mask-Driven Bit Gather/Scatter Unit

This block is a sequential 48-bit bit-manipulation engine offering three operations on a value word, two of which are steered by a mask word. The gather operation takes the value bits that sit under set mask bits and packs them, in their original relative order, against the most-significant end of the result. The scatter operation does the reverse. It draws bits from the most-significant end of the value and places them, one by one, into the set mask positions. It scans from the top of the word downward. The population count returns how many ones the value holds.

A caller presents an opcode, a value and a mask, and pulses `start` while the unit is idle. The unit then works one bit position per clock. It raises `busy` for the duration and finishes with a single-cycle `done` pulse, at which point `result` carries the answer. The result stays on the port until the next finished operation. Gather stops as soon as no set mask bits remain. Scatter always walks all 48 positions. Population count stops once the working copy of the value has no ones left. A gather followed by a scatter with the same mask returns the value with every unmasked bit cleared.

Reset is asynchronous and active low. It is released inside the block through a two-stage synchronizer, so the unit accepts its first `start` two clock edges after `rst_n` rises.

Top module: `gather_scatter_unit`

## Requirements
- R1: With opcode 00 (gather), when the mask has n set bits, result bits 47 down to 48-n hold the value bits found under those set mask bits. The bit under the lowest set mask bit lands at 48-n, and the order is kept upward. All result bits below 48-n are zero.
- R2: A gather finishes, with `done` high, h+2 clock edges after the edge that accepted `start`, where h is the index of the highest set mask bit. With a zero mask it finishes after 1 edge and the result is zero.
- R3: With opcode 01 (scatter), the result is built by walking positions 47 down to 0. A position whose mask bit is set receives the next unused value bit, beginning with value bit 47. A position whose mask bit is clear receives 0 and uses no value bit.
- R4: A scatter finishes 49 clock edges after the edge that accepted `start`, whatever the mask.
- R5: With opcode 10 (population count), the result is the number of ones in the value, as a 6-bit count in bits 5:0 with bits 47:6 zero. It finishes k+1 edges after the accepting edge, where k is that count.
- R6: Opcode 11 is reserved. It finishes 1 edge after the accepting edge with a zero result.
- R7: `done` is high for exactly one cycle and never together with `busy`. `busy` is high from the accepting edge until the finishing edge. `result` changes only on a finishing edge and otherwise holds its value.
- R8: A `start` pulse seen while `busy` is high is ignored. The running operation finishes with its own result and latency, and no extra `done` follows.
- R9: While reset is held, and after its release until the first finished operation, `busy` and `done` are 0 and `result` is 0.
- R10: A gather of value v with mask m, followed by a scatter of that gather result with the same m, yields v AND m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation; taken only while idle |
| opcode | input | 2 | 00 gather, 01 scatter, 10 population count, 11 reserved |
| value | input | 48 | Source data word |
| mask | input | 48 | Selection mask for gather and scatter |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: result is valid from this cycle |
| result | output | 48 | Result of the last finished operation |

## Verification
A corrupted working register shows up at the ports in one of two ways. A stuck or misshifted mask copy changes the finishing edge of a gather, so `done` arrives early or late by at least one cycle. A bad value or accumulator copy puts wrong or misordered bits into `result` on the very `done` pulse of that operation. An off-by-one in the scatter position counter moves its 49-edge latency. A popcount that stops clearing bits keeps `busy` high well past its expected count. For these reasons the bench checks both the result word and the exact completion cycle of every operation. It also checks, in the cycle after each `done`, that the pulse has ended and the result is held.

// File: rtl/gs_pkg.sv
package gs_pkg;

  typedef enum logic [1:0] {
    OP_GATHER  = 2'b00,
    OP_SCATTER = 2'b01,
    OP_POPCNT  = 2'b10,
    OP_RSVD    = 2'b11
  } gs_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } gs_state_e;

endpackage

// File: rtl/gs_rst_sync.sv
module gs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gs_ctrl.sv
module gs_ctrl
  import gs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic finish,
  output logic busy,
  output logic load,
  output logic step,
  output logic fin,
  output logic done
);

  gs_state_e state_q, state_d;
  logic      done_d;

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    step    = 1'b0;
    fin     = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          load    = 1'b1;
        end
      end
      ST_RUN: begin
        if (finish) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
          done_d  = 1'b1;
        end else begin
          step = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  assign busy = (state_q == ST_RUN);

  // R7: completion pulse lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: busy and done are never high together
  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R8: start during a run neither ends nor restarts it
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !finish) |=> busy);

endmodule

// File: rtl/gs_gather_step.sv
module gs_gather_step #(
  parameter int W = 48
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] msk,
  input  logic [W-1:0] acc,
  output logic [W-1:0] val_n,
  output logic [W-1:0] msk_n,
  output logic [W-1:0] acc_n,
  output logic         empty
);

  always_comb begin
    val_n = val >> 1;
    msk_n = msk >> 1;
    if (msk[0]) acc_n = {val[0], acc[W-1:1]};
    else        acc_n = acc;
    empty = (msk == '0);
  end

endmodule

// File: rtl/gs_scatter_step.sv
module gs_scatter_step #(
  parameter int W = 48
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] msk,
  input  logic [W-1:0] acc,
  output logic [W-1:0] val_n,
  output logic [W-1:0] msk_n,
  output logic [W-1:0] acc_n
);

  always_comb begin
    acc_n = {acc[W-2:0], msk[W-1] & val[W-1]};
    msk_n = msk << 1;
    if (msk[W-1]) val_n = val << 1;
    else          val_n = val;
  end

endmodule

// File: rtl/gs_popcnt_step.sv
module gs_popcnt_step #(
  parameter int W  = 48,
  parameter int CW = 6
) (
  input  logic [W-1:0]  val,
  input  logic [CW-1:0] cnt,
  output logic [W-1:0]  val_n,
  output logic [CW-1:0] cnt_n,
  output logic          empty
);

  always_comb begin
    val_n = val & (val - W'(1));
    cnt_n = cnt + CW'(1);
    empty = (val == '0);
  end

endmodule

// File: rtl/gather_scatter_unit.sv
module gather_scatter_unit
  import gs_pkg::*;
#(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   opcode,
  input  logic [W-1:0] value,
  input  logic [W-1:0] mask,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);

  localparam int CW = $clog2(W + 1);

  logic rst_n_s;

  gs_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // working state
  gs_op_e        op_q, op_d;
  logic [W-1:0]  val_q, val_d;
  logic [W-1:0]  msk_q, msk_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  res_q, res_d;

  logic load, step, fin, finish;
  logic work_en, res_en;

  gs_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .start  (start),
    .finish (finish),
    .busy   (busy),
    .load   (load),
    .step   (step),
    .fin    (fin),
    .done   (done)
  );

  logic [W-1:0] g_val, g_msk, g_acc;
  logic         g_empty;
  logic [W-1:0] s_val, s_msk, s_acc;
  logic [W-1:0] p_val;
  logic [CW-1:0] p_cnt;
  logic         p_empty;

  gs_gather_step #(.W(W)) u_gather (
    .val   (val_q),
    .msk   (msk_q),
    .acc   (acc_q),
    .val_n (g_val),
    .msk_n (g_msk),
    .acc_n (g_acc),
    .empty (g_empty)
  );

  gs_scatter_step #(.W(W)) u_scatter (
    .val   (val_q),
    .msk   (msk_q),
    .acc   (acc_q),
    .val_n (s_val),
    .msk_n (s_msk),
    .acc_n (s_acc)
  );

  gs_popcnt_step #(.W(W), .CW(CW)) u_popcnt (
    .val   (val_q),
    .cnt   (cnt_q),
    .val_n (p_val),
    .cnt_n (p_cnt),
    .empty (p_empty)
  );

  // completion condition per operation
  always_comb begin
    unique case (op_q)
      OP_GATHER:  finish = g_empty;
      OP_SCATTER: finish = (cnt_q == CW'(W));
      OP_POPCNT:  finish = p_empty;
      default:    finish = 1'b1;
    endcase
  end

  // next state of the working registers
  always_comb begin
    op_d  = op_q;
    val_d = val_q;
    msk_d = msk_q;
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (load) begin
      op_d  = gs_op_e'(opcode);
      val_d = value;
      msk_d = mask;
      acc_d = '0;
      cnt_d = '0;
    end else if (step) begin
      unique case (op_q)
        OP_GATHER: begin
          val_d = g_val;
          msk_d = g_msk;
          acc_d = g_acc;
        end
        OP_SCATTER: begin
          val_d = s_val;
          msk_d = s_msk;
          acc_d = s_acc;
          cnt_d = cnt_q + CW'(1);
        end
        OP_POPCNT: begin
          val_d = p_val;
          cnt_d = p_cnt;
        end
        default: ;
      endcase
    end
  end

  // result selection at completion
  always_comb begin
    unique case (op_q)
      OP_GATHER, OP_SCATTER: res_d = acc_q;
      OP_POPCNT:             res_d = {{(W-CW){1'b0}}, cnt_q};
      default:               res_d = '0;
    endcase
  end

  assign work_en = load | step;
  assign res_en  = fin;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      op_q  <= OP_GATHER;
      val_q <= '0;
      msk_q <= '0;
      acc_q <= '0;
      cnt_q <= '0;
    end else if (work_en) begin
      op_q  <= op_d;
      val_q <= val_d;
      msk_q <= msk_d;
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign result = res_q;

  // R7: result moves only together with a done pulse
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done || $stable(result)));

  // R8: the latched opcode does not change while running
  p_op_stable_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy |=> (!busy || op_q == $past(op_q)));

  // R2: a gather step never adds set bits to the remaining mask
  p_gather_shrink_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && op_q == OP_GATHER) |=>
      (!busy || $countones(msk_q) <= $countones($past(msk_q))));

  // R4: scatter position counter never passes the word width
  p_scatter_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && op_q == OP_SCATTER) |-> (cnt_q <= CW'(W)));

  // R5: a population count result fits in its count field
  p_popcnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && op_q == OP_POPCNT) |-> (result[W-1:CW] == '0));

  // R9: idle and clear while the synchronized reset is held
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n_s |-> (!busy && !done && result == '0));

endmodule

// File: tb/sim_gather_scatter_unit.sv
`timescale 1ns/1ps
module sim_gather_scatter_unit;

  localparam int W = 48;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1:0]   opcode;
  logic [W-1:0] value;
  logic [W-1:0] mask;
  logic         busy;
  logic         done;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [W-1:0] exp;
    int           lat;
    int           t0;
    string        tag;
  } item_t;

  item_t sb_q[$];

  gather_scatter_unit #(.W(W)) u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .opcode (opcode),
    .value  (value),
    .mask   (mask),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // reference models taken from the requirement text
  function automatic logic [W-1:0] ref_gather(logic [W-1:0] v, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    for (int i = 0; i < W; i++)
      if (m[i]) r = {v[i], r[W-1:1]};
    return r;
  endfunction

  function automatic logic [W-1:0] ref_scatter(logic [W-1:0] v, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int k = W - 1;
    for (int i = W - 1; i >= 0; i--)
      if (m[i]) begin
        r[i] = v[k];
        k--;
      end
    return r;
  endfunction

  function automatic int ref_ones(logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic int ref_lat(logic [1:0] op, logic [W-1:0] v, logic [W-1:0] m);
    int h = -1;
    case (op)
      2'b00: begin
        for (int i = 0; i < W; i++) if (m[i]) h = i;
        return (h < 0) ? 1 : h + 2;
      end
      2'b01:   return W + 1;
      2'b10:   return ref_ones(v) + 1;
      default: return 1;
    endcase
  endfunction

  function automatic logic [W-1:0] ref_res(logic [1:0] op, logic [W-1:0] v, logic [W-1:0] m);
    case (op)
      2'b00:   return ref_gather(v, m);
      2'b01:   return ref_scatter(v, m);
      2'b10:   return W'(ref_ones(v));
      default: return '0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: issue one operation, optionally poke start while it runs
  task automatic run_op(logic [1:0] op, logic [W-1:0] v, logic [W-1:0] m,
                        string tag, bit poke, logic [W-1:0] exp_over);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    opcode = op;
    value  = v;
    mask   = m;
    start  = 1'b1;
    it.exp = exp_over;
    it.lat = ref_lat(op, v, m);
    it.t0  = cyc + 1;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      opcode = 2'b10;
      value  = '1;
      mask   = '0;
      start  = 1'b1;
      @(negedge clk);
      start  = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic op(logic [1:0] o, logic [W-1:0] v, logic [W-1:0] m, string tag);
    run_op(o, v, m, tag, 1'b0, ref_res(o, v, m));
  endtask

  // monitor: compare each completion with the scoreboard
  bit           chk_after = 1'b0;
  logic [W-1:0] held;
  string        held_tag;

  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_after) begin
        chk_after = 1'b0;
        check(!done && result == held, "R7", result, held);
      end
      if (done) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R8", result, '0);
        end else begin
          item_t it;
          it = sb_q.pop_front();
          check(result == it.exp, it.tag, result, it.exp);
          check((cyc - it.t0) == it.lat, {it.tag, " latency"},
                W'(cyc - it.t0), W'(it.lat));
          held      = result;
          held_tag  = it.tag;
          chk_after = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v1, m1, g;
    rst_n  = 1'b0;
    start  = 1'b0;
    opcode = 2'b00;
    value  = '0;
    mask   = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && result == '0, "R9", result, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && !done && result == '0, "R9", result, '0);

    // R1 / R2: gather
    op(2'b00, 48'hA5A5_0F0F_1234, 48'hFFFF_0000_FF00, "R1");
    op(2'b00, 48'h1234_5678_9ABC, 48'h0000_0000_0000, "R2");
    op(2'b00, 48'h1234_5678_9ABC, 48'hFFFF_FFFF_FFFF, "R1");
    op(2'b00, 48'h0000_0000_0001, 48'h0000_0000_0001, "R2");
    op(2'b00, 48'h8000_0000_0000, 48'h8000_0000_0000, "R2");
    op(2'b00, 48'hDEAD_BEEF_CAFE, 48'h5555_AAAA_0F0F, "R1");

    // R3 / R4: scatter
    op(2'b01, 48'hC000_0000_0000, 48'h0000_0001_0001, "R3");
    op(2'b01, 48'hF0E1_D2C3_B4A5, 48'h0F0F_0000_FFFF, "R3");
    op(2'b01, 48'h1234_5678_9ABC, 48'h0000_0000_0000, "R4");
    op(2'b01, 48'h1234_5678_9ABC, 48'hFFFF_FFFF_FFFF, "R3");

    // R5: population count
    op(2'b10, 48'h0000_0000_0000, 48'h0, "R5");
    op(2'b10, 48'hFFFF_FFFF_FFFF, 48'h0, "R5");
    op(2'b10, 48'h8001_0000_0101, 48'h0, "R5");

    // R6: reserved opcode
    op(2'b11, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, "R6");

    // R8: start poked in the middle of a scatter
    run_op(2'b01, 48'hABCD_EF01_2345, 48'h00FF_FF00_F0F0, "R8", 1'b1,
           ref_scatter(48'hABCD_EF01_2345, 48'h00FF_FF00_F0F0));

    // R10: gather then scatter with the same mask
    v1 = 48'h9C3A_57E1_0B6D;
    m1 = 48'h3F0C_A5A5_1E87;
    g  = ref_gather(v1, m1);
    op(2'b00, v1, m1, "R10");
    run_op(2'b01, g, m1, "R10", 1'b0, v1 & m1);
    v1 = 48'hFFFF_0000_FFFF;
    m1 = 48'h8421_8421_8421;
    g  = ref_gather(v1, m1);
    op(2'b00, v1, m1, "R10");
    run_op(2'b01, g, m1, "R10", 1'b0, v1 & m1);

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R8", W'(sb_q.size()), '0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule